// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block holds micro-ops between rename and commit in an out-of-order core. Each cycle the front end may hand it up to three micro-ops in program order. Each micro-op carries three things: the internal (physical) register it writes, the architectural register that the physical register stands for, and a flag that marks the last micro-op of its instruction. The block returns the circular index of the first slot it filled. Execution units report completion by slot index, in any order, and may mark a micro-op as faulting.

The oldest instructions leave the buffer in allocation order, at most three micro-ops per cycle. An instruction leaves only as a whole, once every one of its micro-ops has executed. As each micro-op retires, the block records its architectural-to-physical mapping in a committed map, which undoes the renaming for the state software can see. A fault is reported only when the faulting instruction becomes the oldest in the buffer and has fully executed. In the cycle after the report, every entry in the buffer is discarded and allocation resumes at the faulting slot.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready` is 1, `alloc_idx` is 0, `ret_valid` and `exc_valid` are 0, and `arch_map` holds the identity mapping (architectural register r maps to physical register r; field r occupies bits [r*PW +: PW]).
- R2: A request with `alloc_cnt` = n (1..3) and `alloc_ready` = 1 writes lanes 0..n-1 to slots `alloc_idx`, `alloc_idx`+1 and `alloc_idx`+2. Lane k of each alloc bus sits at bits [k*W +: W]. `alloc_idx` advances by n at that clock edge.
- R3: `alloc_ready` is 0 when fewer than three slots are free or while `exc_valid` is 1. A request made while it is 0 is ignored, and `alloc_idx` does not change.
- R4: A writeback marks its slot as executed, and writebacks may arrive in any slot order. Two writeback ports act in the same cycle, and port p's index is at `wb_idx`[p*IW +: IW]. At most three micro-ops retire per cycle.
- R5: Retirement is in allocation order. In the cycle after the edge on which the oldest slots become executed, `ret_valid` shows them on lanes 0, 1, 2 from oldest to youngest, lanes filled from lane 0 up, with `ret_areg` and `ret_preg` alongside. A younger executed slot never retires ahead of an older one that has not executed.
- R6: An instruction (a run of micro-ops ending with last = 1, at most three long) retires only in a cycle where all of its micro-ops have executed, and all of them retire together.
- R7: `arch_map` takes each retiring lane's physical register for its architectural register at the retiring edge. When two lanes in one cycle name the same architectural register, the higher lane wins.
- R8: A fault is deferred. `exc_valid` rises only when the faulting instruction is the oldest in the buffer and all of its micro-ops have executed, and `exc_idx` then gives that instruction's first slot. Older instructions retire first, and no lane retires in a cycle where `exc_valid` is 1.
- R9: At the edge ending an `exc_valid` cycle, every entry is discarded and `alloc_idx` becomes the reported `exc_idx`. The faulting instruction and younger instructions leave `arch_map` untouched.
- R10: A writeback to a slot that holds no entry changes no state, and `wb_bad` for that port is 1 in the same cycle. A writeback to a live slot leaves `wb_bad` at 0.
- R11: Slot indices wrap modulo the buffer depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt | input | LCW | Number of micro-ops offered this cycle (0..3) |
| alloc_preg | input | LANES*PW | Physical destination register per lane |
| alloc_areg | input | LANES*AW | Architectural destination register per lane |
| alloc_last | input | LANES | Last micro-op of its instruction, per lane |
| alloc_ready | output | 1 | At least three slots are free and no fault is being reported |
| alloc_idx | output | IW | Slot that lane 0 will occupy |
| wb_valid | input | WB_PORTS | Completion report per port |
| wb_idx | input | WB_PORTS*IW | Slot index per port |
| wb_exc | input | WB_PORTS | Fault flag per port |
| wb_bad | output | WB_PORTS | The port's writeback targets a slot with no entry |
| ret_valid | output | LANES | Retiring lanes, filled from lane 0 up |
| ret_areg | output | LANES*AW | Architectural register per retiring lane |
| ret_preg | output | LANES*PW | Physical register per retiring lane |
| exc_valid | output | 1 | Fault reported at the oldest instruction |
| exc_idx | output | IW | First slot of the faulting instruction |
| arch_map | output | AREGS*PW | Committed architectural-to-physical map |

## Verification
Allocation, writeback and flush each change the slot state at one clock edge. `alloc_idx`, `ret_valid`, `ret_areg`, `ret_preg` and `exc_valid` are derived from that state alone, so the bench samples them one time unit after the edge that caused the change. `arch_map` follows a retirement by one more edge, so each map check waits for the cycle after `ret_valid` was observed. `wb_bad` depends on the inputs of the current cycle, so it is sampled after the writeback is driven and before the edge. Every expected index, lane pattern and map entry is worked out in the bench from the slot arithmetic modulo depth and from the order of writebacks.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int unsigned ROB_LANES    = 3;
    localparam int unsigned ROB_AREGS    = 8;
    localparam int unsigned ROB_PREGS    = 40;
    localparam int unsigned ROB_DEPTH    = 16;
    localparam int unsigned ROB_WB_PORTS = 2;
endpackage

// File: rtl/rob_retire_sel.sv
// Picks how many of the oldest slots retire this cycle (whole instructions only)
// and whether the oldest complete instruction carries a fault.
module rob_retire_sel #(
    parameter int LANES = 3,
    parameter int LCW   = 2
) (
    input  logic [LANES-1:0] slot_ok,
    input  logic [LANES-1:0] slot_exc,
    input  logic [LANES-1:0] slot_last,
    output logic [LCW-1:0]   ret_n,
    output logic             raise
);
    logic all_ok;
    logic grp_exc;
    logic stop;
    logic first_grp;

    always_comb begin
        ret_n     = '0;
        raise     = 1'b0;
        all_ok    = 1'b1;
        grp_exc   = 1'b0;
        stop      = 1'b0;
        first_grp = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (!stop) begin
                all_ok  = all_ok & slot_ok[k];
                grp_exc = grp_exc | slot_exc[k];
                if (!all_ok) begin
                    stop = 1'b1;
                end else if (slot_last[k]) begin
                    if (grp_exc) begin
                        raise = first_grp;
                        stop  = 1'b1;
                    end else begin
                        ret_n     = LCW'(k + 1);
                        first_grp = 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rob_arch_map.sv
// Committed architectural-to-physical register map, updated by retiring lanes.
module rob_arch_map #(
    parameter int LANES = 3,
    parameter int AREGS = 8,
    parameter int PW    = 6,
    parameter int AW    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    ret_valid,
    input  logic [LANES*AW-1:0] ret_areg,
    input  logic [LANES*PW-1:0] ret_preg,
    output logic [AREGS*PW-1:0] arch_map
);
    logic [AREGS*PW-1:0] map_d, map_q;

    always_comb begin
        map_d = map_q;
        for (int k = 0; k < LANES; k++) begin
            if (ret_valid[k]) begin
                map_d[ret_areg[k*AW +: AW]*PW +: PW] = ret_preg[k*PW +: PW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < AREGS; r++) begin
                map_q[r*PW +: PW] <= PW'(r);
            end
        end else begin
            map_q <= map_d;
        end
    end

    assign arch_map = map_q;
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH    = rob_pkg::ROB_DEPTH,
    parameter int LANES    = rob_pkg::ROB_LANES,
    parameter int AREGS    = rob_pkg::ROB_AREGS,
    parameter int PREGS    = rob_pkg::ROB_PREGS,
    parameter int WB_PORTS = rob_pkg::ROB_WB_PORTS,
    localparam int IW      = $clog2(DEPTH),
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int PW      = $clog2(PREGS),
    localparam int AW      = $clog2(AREGS),
    localparam int LCW     = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LCW-1:0]         alloc_cnt,
    input  logic [LANES*PW-1:0]    alloc_preg,
    input  logic [LANES*AW-1:0]    alloc_areg,
    input  logic [LANES-1:0]       alloc_last,
    output logic                   alloc_ready,
    output logic [IW-1:0]          alloc_idx,
    input  logic [WB_PORTS-1:0]    wb_valid,
    input  logic [WB_PORTS*IW-1:0] wb_idx,
    input  logic [WB_PORTS-1:0]    wb_exc,
    output logic [WB_PORTS-1:0]    wb_bad,
    output logic [LANES-1:0]       ret_valid,
    output logic [LANES*AW-1:0]    ret_areg,
    output logic [LANES*PW-1:0]    ret_preg,
    output logic                   exc_valid,
    output logic [IW-1:0]          exc_idx,
    output logic [AREGS*PW-1:0]    arch_map
);
    typedef struct packed {
        logic [IW-1:0]                head;
        logic [IW-1:0]                tail;
        logic [CW-1:0]                count;
        logic [DEPTH-1:0]             live;
        logic [DEPTH-1:0]             done;
        logic [DEPTH-1:0]             fault;
        logic [DEPTH-1:0]             last;
        logic [DEPTH-1:0][PW-1:0]     preg;
        logic [DEPTH-1:0][AW-1:0]     areg;
    } rob_state_t;

    rob_state_t s_d, s_q;

    logic [LANES-1:0][IW-1:0] win_idx;
    logic [LANES-1:0]         win_ok, win_exc, win_last;
    logic [LCW-1:0]           ret_n;
    logic                     raise;
    logic [LCW-1:0]           take;
    logic                     accept;

    // Retirement window: the LANES oldest slots
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            win_idx[k]  = s_q.head + IW'(k);
            win_ok[k]   = s_q.live[win_idx[k]] & s_q.done[win_idx[k]];
            win_exc[k]  = s_q.fault[win_idx[k]];
            win_last[k] = s_q.last[win_idx[k]];
            ret_areg[k*AW +: AW] = s_q.areg[win_idx[k]];
            ret_preg[k*PW +: PW] = s_q.preg[win_idx[k]];
            ret_valid[k] = (LCW'(k) < ret_n);
        end
    end

    rob_retire_sel #(
        .LANES(LANES),
        .LCW  (LCW)
    ) u_sel (
        .slot_ok  (win_ok),
        .slot_exc (win_exc),
        .slot_last(win_last),
        .ret_n    (ret_n),
        .raise    (raise)
    );

    assign alloc_ready = ((CW'(DEPTH) - s_q.count) >= CW'(LANES)) && !raise;
    assign alloc_idx   = s_q.tail;
    assign exc_valid   = raise;
    assign exc_idx     = s_q.head;
    assign take        = (alloc_cnt > LCW'(LANES)) ? LCW'(LANES) : alloc_cnt;
    assign accept      = (alloc_cnt != '0) && alloc_ready;

    always_comb begin
        s_d    = s_q;
        wb_bad = '0;

        // Completion reports
        for (int p = 0; p < WB_PORTS; p++) begin
            if (wb_valid[p]) begin
                if (s_q.live[wb_idx[p*IW +: IW]]) begin
                    s_d.done[wb_idx[p*IW +: IW]] = 1'b1;
                    if (wb_exc[p]) begin
                        s_d.fault[wb_idx[p*IW +: IW]] = 1'b1;
                    end
                end else begin
                    wb_bad[p] = 1'b1;
                end
            end
        end

        // Retirement
        for (int k = 0; k < LANES; k++) begin
            if (ret_valid[k]) begin
                s_d.live[win_idx[k]] = 1'b0;
            end
        end
        s_d.head  = s_q.head + IW'(ret_n);
        s_d.count = s_q.count - CW'(ret_n);

        // Fault: discard everything, tail back to head
        if (raise) begin
            s_d.live  = '0;
            s_d.tail  = s_q.head;
            s_d.count = '0;
        end

        // Allocation
        if (accept) begin
            for (int k = 0; k < LANES; k++) begin
                if (LCW'(k) < take) begin
                    s_d.live[s_q.tail + IW'(k)]  = 1'b1;
                    s_d.done[s_q.tail + IW'(k)]  = 1'b0;
                    s_d.fault[s_q.tail + IW'(k)] = 1'b0;
                    s_d.last[s_q.tail + IW'(k)]  = alloc_last[k];
                    s_d.preg[s_q.tail + IW'(k)]  = alloc_preg[k*PW +: PW];
                    s_d.areg[s_q.tail + IW'(k)]  = alloc_areg[k*AW +: AW];
                end
            end
            s_d.tail  = s_q.tail + IW'(take);
            s_d.count = s_d.count + CW'(take);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    rob_arch_map #(
        .LANES(LANES),
        .AREGS(AREGS),
        .PW   (PW),
        .AW   (AW)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .ret_valid(ret_valid),
        .ret_areg (ret_areg),
        .ret_preg (ret_preg),
        .arch_map (arch_map)
    );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int LANES    = 3,
    parameter int IW       = 4,
    parameter int WB_PORTS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                alloc_ready,
    input logic [IW-1:0]       alloc_idx,
    input logic [WB_PORTS-1:0] wb_valid,
    input logic [WB_PORTS-1:0] wb_bad,
    input logic [LANES-1:0]    ret_valid,
    input logic                exc_valid,
    input logic [IW-1:0]       exc_idx
);
    a_r5_lanes_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid & (ret_valid + LANES'(1))) == '0);

    a_r8_no_retire_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (ret_valid == '0));

    a_r3_blocked_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !alloc_ready);

    a_r9_tail_to_fault: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (alloc_idx == $past(exc_idx)));

    a_r9_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> ((ret_valid == '0) && !exc_valid));

    a_r3_tail_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !exc_valid) |=> (alloc_idx == $past(alloc_idx)));

    a_r10_flag_needs_report: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_bad & ~wb_valid) == '0);
endmodule

bind rob_core rob_core_chk #(
    .LANES   (LANES),
    .IW      (IW),
    .WB_PORTS(WB_PORTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_ready(alloc_ready),
    .alloc_idx  (alloc_idx),
    .wb_valid   (wb_valid),
    .wb_bad     (wb_bad),
    .ret_valid  (ret_valid),
    .exc_valid  (exc_valid),
    .exc_idx    (exc_idx)
);

// File: tb/sim_rob_core.sv
module sim_rob_core;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int LANES = 3;
    localparam int AREGS = 8;
    localparam int PREGS = 40;
    localparam int WBP   = 2;
    localparam int IW    = 3;
    localparam int PW    = 6;
    localparam int AW    = 3;
    localparam int LCW   = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [LCW-1:0]      alloc_cnt = '0;
    logic [LANES*PW-1:0] alloc_preg = '0;
    logic [LANES*AW-1:0] alloc_areg = '0;
    logic [LANES-1:0]    alloc_last = '0;
    logic                alloc_ready;
    logic [IW-1:0]       alloc_idx;
    logic [WBP-1:0]      wb_valid = '0;
    logic [WBP*IW-1:0]   wb_idx = '0;
    logic [WBP-1:0]      wb_exc = '0;
    logic [WBP-1:0]      wb_bad;
    logic [LANES-1:0]    ret_valid;
    logic [LANES*AW-1:0] ret_areg;
    logic [LANES*PW-1:0] ret_preg;
    logic                exc_valid;
    logic [IW-1:0]       exc_idx;
    logic [AREGS*PW-1:0] arch_map;

    rob_core #(.DEPTH(DEPTH), .LANES(LANES), .AREGS(AREGS), .PREGS(PREGS), .WB_PORTS(WBP)) u0 (
        .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_preg(alloc_preg),
        .alloc_areg(alloc_areg), .alloc_last(alloc_last), .alloc_ready(alloc_ready),
        .alloc_idx(alloc_idx), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_exc(wb_exc),
        .wb_bad(wb_bad), .ret_valid(ret_valid), .ret_areg(ret_areg), .ret_preg(ret_preg),
        .exc_valid(exc_valid), .exc_idx(exc_idx), .arch_map(arch_map));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int exp_map[AREGS];
    int tail_e = 0;
    int la[LANES];
    int lp[LANES];
    int ll[LANES];
    bit last_bad;
    int ord[6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_map(input string tag);
        for (int r = 0; r < AREGS; r++) begin
            chk_eq(tag, int'(arch_map[r*PW +: PW]), exp_map[r]);
        end
    endtask

    task automatic chk_lane(input string tag, input int k, input int a, input int p);
        chk_eq(tag, int'(ret_areg[k*AW +: AW]), a);
        chk_eq(tag, int'(ret_preg[k*PW +: PW]), p);
    endtask

    task automatic drive_alloc(input int n);
        alloc_cnt = LCW'(n);
        for (int k = 0; k < LANES; k++) begin
            alloc_areg[k*AW +: AW] = AW'(la[k]);
            alloc_preg[k*PW +: PW] = PW'(lp[k]);
            alloc_last[k]          = ll[k][0];
        end
    endtask

    task automatic do_alloc(input int n);
        drive_alloc(n);
        tick();
        alloc_cnt = '0;
        tail_e = (tail_e + n) % DEPTH;
    endtask

    task automatic do_wb2(input int n, input int i0, input bit e0, input int i1, input bit e1);
        wb_valid[0] = 1'b1;
        wb_idx[0 +: IW] = IW'(i0 % DEPTH);
        wb_exc[0] = e0;
        if (n > 1) begin
            wb_valid[1] = 1'b1;
            wb_idx[IW +: IW] = IW'(i1 % DEPTH);
            wb_exc[1] = e1;
        end
        #1;
        last_bad = wb_bad[0];
        tick();
        wb_valid = '0;
        wb_exc = '0;
    endtask

    task automatic do_wb(input int i, input bit e);
        do_wb2(1, i, e, 0, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int base;
        for (int r = 0; r < AREGS; r++) exp_map[r] = r;
        #1;
        tick();
        tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk_eq("R1 alloc_ready", int'(alloc_ready), 1);
        chk_eq("R1 alloc_idx", int'(alloc_idx), 0);
        chk_eq("R1 ret_valid", int'(ret_valid), 0);
        chk_eq("R1 exc_valid", int'(exc_valid), 0);
        chk_map("R1 identity map");

        // R2 / R5 / R7: three single-uop instructions, out-of-order completion
        la = '{1, 2, 3}; lp = '{10, 11, 12}; ll = '{1, 1, 1};
        do_alloc(3);
        chk_eq("R2 alloc_idx advance", int'(alloc_idx), 3);
        do_wb(2, 1'b0);
        chk_eq("R10 live writeback not flagged", int'(last_bad), 0);
        chk_eq("R5 younger waits", int'(ret_valid), 0);
        do_wb(0, 1'b0);
        chk_eq("R5 oldest retires", int'(ret_valid), 1);
        chk_lane("R5 lane0 fields", 0, 1, 10);
        tick();
        exp_map[1] = 10;
        chk_map("R7 map after retire");
        chk_eq("R5 blocked by slot 1", int'(ret_valid), 0);
        do_wb(1, 1'b0);
        chk_eq("R5 two retire", int'(ret_valid), 3);
        chk_lane("R5 lane0", 0, 2, 11);
        chk_lane("R5 lane1", 1, 3, 12);
        tick();
        exp_map[2] = 11; exp_map[3] = 12;
        chk_map("R7 map two lanes");

        // R6 / R4 / R11: every completion order of a three-uop instruction
        for (int q = 0; q < 6; q++) begin
            base = tail_e;
            la = '{4, 5, 6};
            lp = '{13 + q*3, 14 + q*3, 15 + q*3};
            ll = '{0, 0, 1};
            do_alloc(3);
            chk_eq("R11 alloc_idx wraps", int'(alloc_idx), tail_e);
            for (int j = 0; j < 3; j++) begin
                do_wb(base + ord[q][j], 1'b0);
                if (j < 2) chk_eq("R6 partial instruction held", int'(ret_valid), 0);
                else       chk_eq("R6 whole instruction retires", int'(ret_valid), 7);
            end
            chk_lane("R6 lane2", 2, 6, 15 + q*3);
            tick();
            exp_map[4] = 13 + q*3; exp_map[5] = 14 + q*3; exp_map[6] = 15 + q*3;
            chk_eq("R6 nothing left", int'(ret_valid), 0);
        end
        chk_map("R7 map after sweep");

        // R3 / R4: fill, back-pressure, three per cycle
        base = tail_e;
        la = '{0, 1, 2}; lp = '{31, 32, 33}; ll = '{1, 1, 1};
        do_alloc(3);
        chk_eq("R3 ready with five free", int'(alloc_ready), 1);
        la = '{3, 4, 5}; lp = '{34, 35, 36};
        do_alloc(3);
        chk_eq("R3 ready low with two free", int'(alloc_ready), 0);
        la = '{7, 7, 7}; lp = '{1, 1, 1};
        drive_alloc(3);
        tick();
        alloc_cnt = '0;
        chk_eq("R3 ignored request", int'(alloc_idx), tail_e);
        do_wb2(2, base + 5, 1'b0, base + 4, 1'b0);
        do_wb2(2, base + 3, 1'b0, base + 2, 1'b0);
        chk_eq("R4 none before oldest", int'(ret_valid), 0);
        do_wb2(2, base + 1, 1'b0, base + 0, 1'b0);
        chk_eq("R4 three of six retire", int'(ret_valid), 7);
        chk_lane("R4 first group lane0", 0, 0, 31);
        tick();
        exp_map[0] = 31; exp_map[1] = 32; exp_map[2] = 33;
        chk_eq("R4 next three retire", int'(ret_valid), 7);
        chk_lane("R4 second group lane2", 2, 5, 36);
        chk_map("R7 map first group");
        tick();
        exp_map[3] = 34; exp_map[4] = 35; exp_map[5] = 36;
        chk_eq("R4 drained", int'(ret_valid), 0);
        chk_eq("R3 ready again", int'(alloc_ready), 1);
        chk_map("R7 map second group");

        // R8 / R9: deferred fault and flush
        base = tail_e;
        la = '{6, 7, 1}; lp = '{37, 38, 39}; ll = '{1, 1, 1};
        do_alloc(3);
        do_wb(base + 1, 1'b1);
        chk_eq("R8 fault not yet oldest", int'(exc_valid), 0);
        do_wb(base + 0, 1'b0);
        chk_eq("R8 older retires first", int'(ret_valid), 1);
        chk_eq("R8 no fault with older pending", int'(exc_valid), 0);
        tick();
        exp_map[6] = 37;
        chk_eq("R8 fault raised", int'(exc_valid), 1);
        chk_eq("R8 exc_idx", int'(exc_idx), (base + 1) % DEPTH);
        chk_eq("R8 no lane on fault", int'(ret_valid), 0);
        chk_eq("R3 ready low on fault", int'(alloc_ready), 0);
        tick();
        tail_e = (base + 1) % DEPTH;
        chk_eq("R9 tail to fault slot", int'(alloc_idx), tail_e);
        chk_eq("R9 fault cleared", int'(exc_valid), 0);
        chk_map("R9 map untouched by flushed");
        do_wb(base + 2, 1'b0);
        chk_eq("R9 flushed slot is empty", int'(last_bad), 1);
        chk_eq("R9 nothing retires", int'(ret_valid), 0);

        // R10: stray writeback ignored
        base = tail_e;
        do_wb(base, 1'b0);
        chk_eq("R10 stray flagged", int'(last_bad), 1);
        la = '{2, 0, 0}; lp = '{5, 0, 0}; ll = '{1, 0, 0};
        do_alloc(1);
        chk_eq("R10 stray left no mark", int'(ret_valid), 0);
        do_wb(base, 1'b0);
        chk_eq("R10 real completion", int'(ret_valid), 1);
        tick();
        exp_map[2] = 5;
        chk_map("R10 map");

        // R7: same architectural register twice in one cycle
        base = tail_e;
        la = '{3, 3, 0}; lp = '{8, 9, 0}; ll = '{1, 1, 0};
        do_alloc(2);
        do_wb2(2, base + 1, 1'b0, base, 1'b0);
        chk_eq("R7 both retire", int'(ret_valid), 3);
        tick();
        exp_map[3] = 9;
        chk_map("R7 higher lane wins");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule